// File: doc/BRIEF.md
# Fast/Trickle Charge Mode Controller

This block decides whether a rechargeable battery pack gets full charging current (fast) or a maintenance current (trickle). It starts in fast mode after power-on reset. Seven synchronous condition flags, produced elsewhere by comparators, a thermistor interface and a charge timer, are registered on entry. Each of the five trickle causes is then held by its own rule.

Some causes clear when their condition goes away: the sense voltage returning inside its window, or the pack warming up after being too cold. Others stay set until the next power-on reset: overheating, charge timer expiry, and negative-slope end-of-charge. A negative-slope pulse counts only while the holdoff flag reports that the holdoff period has elapsed. The fast/trickle output is registered. It shows fast only when no cause bit is set. The cause bits are exported so the reason for trickle can be seen.

Top module: `chg_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `fast_o` is 1 and `cause_o` is all zero.
- R2: When `v_hi` or `v_lo` is 1, `cause_o[0]` becomes 1 and `fast_o` becomes 0. Both change SYNC_STAGES+1 rising edges after the flag is applied.
- R3: `cause_o[0]` clears once both `v_hi` and `v_lo` are 0, whichever of them was set before. The same latency as in R2 applies.
- R4: A `slope_drop` pulse while `hold_done` is 1 sets `cause_o[4]`. The bit stays set, with `fast_o` at 0, until reset, whatever the other inputs do.
- R5: A `slope_drop` pulse while `hold_done` is 0 leaves `cause_o[4]` at 0 and `fast_o` unchanged.
- R6: `t_cold` sets `cause_o[1]`. The bit clears when `t_cold` returns to 0.
- R7: `t_hot` sets `cause_o[2]`. The bit stays set until reset, even after `t_hot` returns to 0.
- R8: `tmr_done` sets `cause_o[3]`. With TMR_STICKY=1 (the default), the bit stays set until reset.
- R9: When several causes are active, `fast_o` returns to 1 only after every cause bit has been cleared by its own rule.
- R10: `fast_o` is a register output. Outside reset, it is 1 exactly when `cause_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low power-on reset |
| v_hi | input | 1 | Sense voltage above upper window limit (pack open) |
| v_lo | input | 1 | Sense voltage below lower window limit (shorted cell) |
| t_cold | input | 1 | Pack temperature below range |
| t_hot | input | 1 | Pack temperature above range |
| tmr_done | input | 1 | Charge timer has expired |
| hold_done | input | 1 | Holdoff period since fast start has elapsed (level) |
| slope_drop | input | 1 | Negative voltage slope detected (pulse) |
| fast_o | output | 1 | 1 = fast charge, 0 = trickle |
| cause_o | output | 5 | Trickle causes: [0] voltage window, [1] cold, [2] hot, [3] timer, [4] negative slope |

## Verification
The assertions assume that every flag is already synchronous to `clk`, so a value sampled at one edge is taken to be the condition at that moment. They also assume that `hold_done` behaves as a level flag, while `slope_drop` may be a single-cycle pulse. The stimulus changes inputs only on falling clock edges and never toggles a flag during reset. After each change it waits the full SYNC_STAGES+1 edges before it compares the outputs. The bench sweeps all 32 combinations of the five level flags, applying each one and then removing it, and runs separate sequences for the gated slope pulse and for causes that overlap.

// File: rtl/chg_mode_pkg.sv
package chg_mode_pkg;
   // input flag vector positions
   localparam int FL_VHI   = 0;
   localparam int FL_VLO   = 1;
   localparam int FL_COLD  = 2;
   localparam int FL_HOT   = 3;
   localparam int FL_TMR   = 4;
   localparam int FL_HOLD  = 5;
   localparam int FL_SLOPE = 6;
   localparam int NUM_FLAG = 7;
   // cause vector positions (exported on cause_o)
   localparam int CZ_VWIN  = 0;
   localparam int CZ_COLD  = 1;
   localparam int CZ_HOT   = 2;
   localparam int CZ_TMR   = 3;
   localparam int CZ_SLOPE = 4;
   localparam int NUM_CAUSE = 5;
   typedef logic [NUM_FLAG-1:0]  flag_vec_t;
   typedef logic [NUM_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/chg_flag_sync.sv
module chg_flag_sync #(
   parameter int W      = 7,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1 || STAGES > 4) begin : g_bad_stages
      $error("chg_flag_sync: STAGES must be 1..4");
   end
   if (W < 1) begin : g_bad_w
      $error("chg_flag_sync: W must be positive");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end else begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[0] <= '0;
         else        stg[0] <= d;
      end
      for (genvar i = 1; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= '0;
            else        stg[i] <= stg[i-1];
         end
      end
      assign q = stg[STAGES-1];
   end
endmodule

// File: rtl/chg_cause_reg.sv
module chg_cause_reg
   import chg_mode_pkg::*;
#(
   parameter bit TMR_STICKY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  flag_vec_t  flg,
   output cause_vec_t cause_d,
   output cause_vec_t cause_q
);
   logic slope_ok;
   assign slope_ok = flg[FL_SLOPE] & flg[FL_HOLD];

   always_comb begin
      cause_d[CZ_VWIN]  = flg[FL_VHI] | flg[FL_VLO];
      cause_d[CZ_COLD]  = flg[FL_COLD];
      cause_d[CZ_HOT]   = cause_q[CZ_HOT] | flg[FL_HOT];
      cause_d[CZ_SLOPE] = cause_q[CZ_SLOPE] | slope_ok;
      cause_d[CZ_TMR]   = flg[FL_TMR];
      if (TMR_STICKY) cause_d[CZ_TMR] = cause_q[CZ_TMR] | flg[FL_TMR];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= cause_d;
   end

   AST_SLOPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cause_q[CZ_SLOPE] |=> cause_q[CZ_SLOPE]);                          // R4
   AST_SLOPE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_q[CZ_SLOPE]) |-> $past(flg[FL_HOLD] && flg[FL_SLOPE])); // R5
   AST_HOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      cause_q[CZ_HOT] |=> cause_q[CZ_HOT]);                              // R7
   AST_COLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !flg[FL_COLD] |=> !cause_q[CZ_COLD]);                              // R6
   AST_VWIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !(flg[FL_VHI] || flg[FL_VLO]) |=> !cause_q[CZ_VWIN]);              // R3
   if (TMR_STICKY) begin : g_tmr_chk
      AST_TMR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
         cause_q[CZ_TMR] |=> cause_q[CZ_TMR]);                           // R8
   end
endmodule

// File: rtl/chg_mode_out.sv
module chg_mode_out
   import chg_mode_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cause_vec_t cause_d,
   output logic       fast_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fast_q <= 1'b1;
      else        fast_q <= ~|cause_d;
   end

   AST_TRICKLE_ON_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (|cause_d) |=> !fast_q);                                            // R9
endmodule

// File: rtl/chg_mode_ctrl.sv
module chg_mode_ctrl
   import chg_mode_pkg::*;
#(
   parameter int SYNC_STAGES = 1,
   parameter bit TMR_STICKY  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       v_hi,
   input  logic       v_lo,
   input  logic       t_cold,
   input  logic       t_hot,
   input  logic       tmr_done,
   input  logic       hold_done,
   input  logic       slope_drop,
   output logic       fast_o,
   output logic [4:0] cause_o
);
   if (NUM_CAUSE != 5) begin : g_bad_pkg
      $error("chg_mode_ctrl: cause vector width mismatch");
   end

   flag_vec_t  raw, flg;
   cause_vec_t c_d, c_q;

   always_comb begin
      raw              = '0;
      raw[FL_VHI]      = v_hi;
      raw[FL_VLO]      = v_lo;
      raw[FL_COLD]     = t_cold;
      raw[FL_HOT]      = t_hot;
      raw[FL_TMR]      = tmr_done;
      raw[FL_HOLD]     = hold_done;
      raw[FL_SLOPE]    = slope_drop;
   end

   chg_flag_sync #(.W(NUM_FLAG), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(flg));

   chg_cause_reg #(.TMR_STICKY(TMR_STICKY)) u_cause (
      .clk(clk), .rst_n(rst_n), .flg(flg), .cause_d(c_d), .cause_q(c_q));

   chg_mode_out u_out (
      .clk(clk), .rst_n(rst_n), .cause_d(c_d), .fast_q(fast_o));

   assign cause_o = c_q;

   AST_FAST_MEANS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      fast_o |-> (cause_o == '0));                                        // R10
   AST_CAUSE_MEANS_TRICKLE: assert property (@(posedge clk) disable iff (!rst_n)
      (|cause_o) |-> !fast_o);                                            // R10
endmodule

// File: tb/chg_mode_ctrl_tb.sv
module chg_mode_ctrl_tb_top;
   localparam int CLK_P = 10;
   localparam int SYNC  = 1;
   localparam int LAT   = SYNC + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic v_hi = 0, v_lo = 0, t_cold = 0, t_hot = 0, tmr_done = 0;
   logic hold_done = 0, slope_drop = 0;
   logic fast_o;
   logic [4:0] cause_o;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   chg_mode_ctrl #(.SYNC_STAGES(SYNC), .TMR_STICKY(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .v_hi(v_hi), .v_lo(v_lo), .t_cold(t_cold),
      .t_hot(t_hot), .tmr_done(tmr_done), .hold_done(hold_done),
      .slope_drop(slope_drop), .fast_o(fast_o), .cause_o(cause_o));

   task automatic check(input string req, input logic [5:0] exp);
      checks++;
      if ({fast_o, cause_o} !== exp) begin
         errors++;
         $display("FAIL %s: got fast=%b cause=%b expected fast=%b cause=%b",
                  req, fast_o, cause_o, exp[5], exp[4:0]);
      end
   endtask

   task automatic clear_flags();
      {v_hi, v_lo, t_cold, t_hot, tmr_done, hold_done, slope_drop} = '0;
   endtask

   task automatic settle();
      repeat (LAT) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      clear_flags();
      repeat (2) @(negedge clk);
      check("R1 during reset", 6'b100000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 6'b100000);
   endtask

   function automatic logic [5:0] pack(input logic [4:0] c);
      return {(c == 5'b0), c};
   endfunction

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // Sweep all level-flag combinations: R2 R3 R6 R7 R8 R10
      for (int m = 0; m < 32; m++) begin
         logic [4:0] ea, ec;
         do_reset();
         {tmr_done, t_hot, t_cold, v_lo, v_hi} = m[4:0];
         ea = {1'b0, m[4], m[3], m[2], m[0] | m[1]};
         settle();
         check("R2 R6 R7 R8 R10 apply", pack(ea));
         clear_flags();
         ec = {1'b0, m[4], m[3], 1'b0, 1'b0};
         settle();
         check("R3 R6 R7 R8 R9 release", pack(ec));
      end

      // R5: slope pulse before holdoff is ignored
      do_reset();
      @(negedge clk); slope_drop = 1;
      @(negedge clk); slope_drop = 0;
      settle();
      check("R5 slope before holdoff", 6'b100000);

      // R4: slope pulse after holdoff latches
      hold_done = 1;
      @(negedge clk); slope_drop = 1;
      @(negedge clk); slope_drop = 0;
      settle();
      check("R4 slope after holdoff", 6'b010000);
      hold_done = 0;
      repeat (5) @(negedge clk);
      check("R4 slope held", 6'b010000);
      v_hi = 1; settle(); v_hi = 0; settle();
      check("R4 slope held after window blip", 6'b010000);
      do_reset();

      // R3: high then low then back into window
      v_hi = 1; settle();
      check("R2 over window", 6'b000001);
      v_hi = 0; v_lo = 1; settle();
      check("R2 under window", 6'b000001);
      v_lo = 0; settle();
      check("R3 window restored", 6'b100000);

      // R9: overlapping causes cleared one by one
      v_lo = 1; t_cold = 1; settle();
      check("R9 two causes", 6'b000011);
      v_lo = 0; settle();
      check("R9 cold remains", 6'b000010);
      t_cold = 0; settle();
      check("R9 all cleared", 6'b100000);

      // R6 with hot: cold recovers, hot does not
      t_cold = 1; t_hot = 1; settle();
      t_cold = 0; t_hot = 0; settle();
      check("R6 R7 cold gone hot kept", 6'b000100);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule